// File: doc/BRIEF.md
# Partitioned SIMD Multiply-Accumulate Unit

This block is a two-stage pipelined packed integer multiplier. It works on 64-bit operands. A partition code cuts each operand into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or two 24-bit lanes. In the 24-bit mode, each 24-bit value sits in the low bits of a 32-bit slot. A sign bit picks signed or unsigned lane arithmetic. One shared array serves every lane width.

Each lane forms a product of double the lane width. The low half of each lane product goes into the matching slot of the low result word, and the high half goes into the same slot of the high result word. The unit also supports four operations:

- multiply and accumulate, using a double-width operand given as low and high words;
- multiply and deduct, using the same kind of operand;
- rounded upper-half multiply;
- plain multiply.

Stage one leaves each product as two partial vectors. Stage two adds those vectors in one carry-save pass together with the accumulate term, the deduct term or the rounding term. It then runs a lane-partitioned carry-propagate add.

A new operation can be issued every cycle, and its result appears two cycles later. Opcode and partition travel with the data through the pipeline, so consecutive operations may use different modes.

Top module: `pmac_simd_unit`

## Requirements
- R1: With `in_signed` = 1, lane operands and lane results are two's-complement. With `in_signed` = 0 they are unsigned.
- R2: An operation presented with `in_valid` high at a rising edge shows its result with `out_valid` high after the second following rising edge. A new operation may be accepted at every edge, and `out_valid` is low when nothing was issued two edges earlier.
- R3: Partition code 00 makes eight 8-bit lanes. Lane i is bits [8i+7:8i], and no carry or product bit crosses a lane boundary.
- R4: Partition code 01 makes four 16-bit lanes. Lane i is bits [16i+15:16i].
- R5: Partition code 10 makes two 32-bit lanes. Lane i is bits [32i+31:32i].
- R6: Partition code 11 makes two 24-bit lanes. Each lane takes bits [32i+23:32i] of each operand and ignores bits [32i+31:32i+24]. The 48-bit product is sign- or zero-extended to 64 bits and laid out like a 32-bit lane.
- R7: Opcode 00 (multiply) writes bits [S-1:0] of each 2S-bit lane product into slot i of `out_lo` and bits [2S-1:S] into slot i of `out_hi`. S is the slot width: 8, 16, 32 or 32.
- R8: Opcode 01 (accumulate) adds the 2S-bit lane value {`in_acc_hi` slot i, `in_acc_lo` slot i} to the product. The sum wraps modulo 2^(2S) and is split as in R7.
- R9: Opcode 10 (deduct) subtracts the same 2S-bit lane value from the product. The difference wraps modulo 2^(2S) and is split as in R7.
- R10: Opcode 11 (rounded upper half) computes (P + 2^(W-1)) >> W for a lane product P and operand width W, with an arithmetic shift when signed. It puts the low S bits of that value into slot i of `out_hi` and drives `out_lo` to zero. The accumulator inputs have no effect.
- R11: Back-to-back operations with different opcode, partition and sign each produce the result their own controls select.
- R12: While `rst_n` is low, `out_valid`, `out_lo` and `out_hi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 2 | 00 multiply, 01 accumulate, 10 deduct, 11 rounded upper half |
| in_part | input | 2 | 00 byte, 01 half, 10 word, 11 24-bit lanes |
| in_signed | input | 1 | 1 signed, 0 unsigned lanes |
| in_a | input | 64 | Packed multiplicand |
| in_b | input | 64 | Packed multiplier |
| in_acc_lo | input | 64 | Low halves of the double-width accumulate operand |
| in_acc_hi | input | 64 | High halves of the double-width accumulate operand |
| out_valid | output | 1 | Result words are valid |
| out_lo | output | 64 | Low halves of the lane results |
| out_hi | output | 64 | High halves of the lane results, or the rounded upper halves |

## Verification
The risky overlap is this: stage two resolves one operation while stage one splits the next operation's product under a different partition and sign. The accumulate, deduct or rounding term then enters the same compressor pass as carries that must be cut at lane starts chosen by the older operation's partition. To provoke it, a long stream issues a new random opcode, partition, sign and operand set every cycle, with occasional idle gaps, after directed sweeps of all-ones, most-negative and zero operands. Every cycle the bench compares each result word and the valid flag against a behavioural lane model delayed by two edges.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

   typedef enum logic [1:0] {
      OP_MUL  = 2'b00,
      OP_MULA = 2'b01,
      OP_MULD = 2'b10,
      OP_MULH = 2'b11
   } pmac_op_e;

   typedef enum logic [1:0] {
      PART_B8  = 2'b00,
      PART_H16 = 2'b01,
      PART_W32 = 2'b10,
      PART_N24 = 2'b11
   } pmac_part_e;

   // width of one double-width result lane in the 2*DW stage-two vector
   function automatic int dbl_w(input logic [1:0] p);
      case (p)
         2'b00:   return 16;
         2'b01:   return 32;
         default: return 64;
      endcase
   endfunction

   // operand width actually multiplied in a lane
   function automatic int opnd_w(input logic [1:0] p, input int narrow_w);
      case (p)
         2'b00:   return 8;
         2'b01:   return 16;
         2'b10:   return 32;
         default: return narrow_w;
      endcase
   endfunction

endpackage

// File: rtl/pmac_pp_stage.sv
// Stage one: per-lane product split in two halves of the multiplier,
// giving a redundant (sum, carry) pair laid out in double-width lanes.
module pmac_pp_stage #(
   parameter int DW = 64,
   parameter int NW = 24
) (
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic            sgn,
   input  logic [1:0]      part,
   output logic [2*DW-1:0] sum,
   output logic [2*DW-1:0] carry
);
   localparam int QW = 2 * DW;

   logic [3:0][QW-1:0] sum_m;
   logic [3:0][QW-1:0] carry_m;

   for (genvar m = 0; m < 4; m++) begin : g_mode
      localparam int S = (m == 0) ? 8 : (m == 1) ? 16 : 32;
      localparam int W = (m == 3) ? NW : S;
      localparam int H = W / 2;
      localparam int D = 2 * S;
      localparam int N = DW / S;

      for (genvar i = 0; i < N; i++) begin : g_lane
         logic [W-1:0]        aw, bw;
         logic signed [D-1:0] ax, blo, bhi, plo, phi;

         assign aw  = a[S*i +: W];
         assign bw  = b[S*i +: W];
         assign ax  = {{(D-W){sgn & aw[W-1]}}, aw};
         assign blo = {{(D-H){1'b0}}, bw[H-1:0]};
         assign bhi = {{(D-(W-H)){sgn & bw[W-1]}}, bw[W-1:H]};
         assign plo = ax * blo;
         assign phi = (ax * bhi) <<< H;

         assign sum_m[m][D*i +: D]   = plo;
         assign carry_m[m][D*i +: D] = phi;
      end
   end

   assign sum   = sum_m[part];
   assign carry = carry_m[part];

endmodule

// File: rtl/pmac_lane_pack.sv
// Lane crossbar: interleaves the accumulator words into double-width lanes
// on the way in, and splits resolved lanes into result words on the way out.
module pmac_lane_pack
   import pmac_pkg::*;
#(
   parameter int DW = 64,
   parameter int NW = 24
) (
   input  logic [DW-1:0]   acc_lo,
   input  logic [DW-1:0]   acc_hi,
   input  logic [1:0]      part_in,
   output logic [2*DW-1:0] acc_dbl,
   input  logic [2*DW-1:0] q,
   input  logic [1:0]      part_out,
   input  pmac_op_e        op_out,
   output logic [DW-1:0]   res_lo,
   output logic [DW-1:0]   res_hi
);
   localparam int QW = 2 * DW;

   logic [3:0][QW-1:0] acc_m;
   logic [3:0][DW-1:0] lo_m, hi_m, rh_m;

   for (genvar m = 0; m < 4; m++) begin : g_mode
      localparam int S = (m == 0) ? 8 : (m == 1) ? 16 : 32;
      localparam int W = (m == 3) ? NW : S;
      localparam int D = 2 * S;
      localparam int N = DW / S;

      for (genvar i = 0; i < N; i++) begin : g_lane
         assign acc_m[m][D*i +: D] = {acc_hi[S*i +: S], acc_lo[S*i +: S]};
         assign lo_m[m][S*i +: S]  = q[D*i +: S];
         assign hi_m[m][S*i +: S]  = q[D*i+S +: S];
         assign rh_m[m][S*i +: S]  = q[D*i+W +: S];
      end
   end

   assign acc_dbl = acc_m[part_in];

   always_comb begin
      if (op_out == OP_MULH) begin
         res_lo = '0;
         res_hi = rh_m[part_out];
      end else begin
         res_lo = lo_m[part_out];
         res_hi = hi_m[part_out];
      end
   end

endmodule

// File: rtl/pmac_part_adder.sv
// Stage two: 3:2 compression of sum, carry and the mode term, then a
// carry-propagate add whose carry is killed at every lane start.
module pmac_part_adder
   import pmac_pkg::*;
#(
   parameter int DW = 64,
   parameter int NW = 24
) (
   input  logic [2*DW-1:0] x,
   input  logic [2*DW-1:0] y,
   input  logic [2*DW-1:0] acc,
   input  pmac_op_e        op,
   input  logic [1:0]      part,
   output logic [2*DW-1:0] q
);
   localparam int QW = 2 * DW;

   logic [QW-1:0] start, rnd, z, s, c;
   logic          inj;

   always_comb begin
      for (int k = 0; k < QW; k++) begin
         start[k] = ((k & (dbl_w(part) - 1)) == 0);
         rnd[k]   = ((k & (dbl_w(part) - 1)) == (opnd_w(part, NW) - 1));
      end
   end

   always_comb begin
      case (op)
         OP_MULA: z = acc;
         OP_MULD: z = ~acc;
         OP_MULH: z = rnd;
         default: z = '0;
      endcase
      inj = (op == OP_MULD);
   end

   always_comb begin
      s    = x ^ y ^ z;
      c[0] = inj;
      for (int k = 1; k < QW; k++) begin
         c[k] = start[k] ? inj
                         : ((x[k-1] & y[k-1]) | (x[k-1] & z[k-1]) | (y[k-1] & z[k-1]));
      end
   end

   always_comb begin
      logic cy;
      cy = 1'b0;
      for (int k = 0; k < QW; k++) begin
         if (start[k]) cy = 1'b0;
         q[k] = s[k] ^ c[k] ^ cy;
         cy   = (s[k] & c[k]) | (s[k] & cy) | (c[k] & cy);
      end
   end

endmodule

// File: rtl/pmac_simd_unit.sv
module pmac_simd_unit
   import pmac_pkg::*;
#(
   parameter int DW = 64,
   parameter int NW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    in_op,
   input  logic [1:0]    in_part,
   input  logic          in_signed,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   input  logic [DW-1:0] in_acc_lo,
   input  logic [DW-1:0] in_acc_hi,
   output logic          out_valid,
   output logic [DW-1:0] out_lo,
   output logic [DW-1:0] out_hi
);
   localparam int QW = 2 * DW;

   if (DW < 32 || (DW % 32) != 0) begin : g_bad_dw
      $error("pmac_simd_unit: DW must be a positive multiple of 32");
   end
   if (NW < 2 || NW > 32 || (NW % 2) != 0) begin : g_bad_nw
      $error("pmac_simd_unit: NW must be even and within 2..32");
   end

   logic [QW-1:0] pp_sum, pp_carry, acc_dbl, add_q;
   logic [DW-1:0] pk_lo, pk_hi;

   logic          s1_valid;
   pmac_op_e      s1_op;
   logic [1:0]    s1_part;
   logic [QW-1:0] s1_sum, s1_carry, s1_acc;

   pmac_pp_stage #(.DW(DW), .NW(NW)) u_pp (
      .a     (in_a),
      .b     (in_b),
      .sgn   (in_signed),
      .part  (in_part),
      .sum   (pp_sum),
      .carry (pp_carry)
   );

   pmac_lane_pack #(.DW(DW), .NW(NW)) u_pack (
      .acc_lo   (in_acc_lo),
      .acc_hi   (in_acc_hi),
      .part_in  (in_part),
      .acc_dbl  (acc_dbl),
      .q        (add_q),
      .part_out (s1_part),
      .op_out   (s1_op),
      .res_lo   (pk_lo),
      .res_hi   (pk_hi)
   );

   pmac_part_adder #(.DW(DW), .NW(NW)) u_add (
      .x    (s1_sum),
      .y    (s1_carry),
      .acc  (s1_acc),
      .op   (s1_op),
      .part (s1_part),
      .q    (add_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= OP_MUL;
         s1_part  <= '0;
         s1_sum   <= '0;
         s1_carry <= '0;
         s1_acc   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_op    <= pmac_op_e'(in_op);
         s1_part  <= in_part;
         s1_sum   <= pp_sum;
         s1_carry <= pp_carry;
         s1_acc   <= acc_dbl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
      end else begin
         out_valid <= s1_valid;
         out_lo    <= pk_lo;
         out_hi    <= pk_hi;
      end
   end

endmodule

// File: rtl/pmac_simd_unit_chk.sv
module pmac_simd_unit_chk #(
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    in_op,
   input logic [DW-1:0] in_a,
   input logic [DW-1:0] in_acc_lo,
   input logic [DW-1:0] in_acc_hi,
   input logic          out_valid,
   input logic [DW-1:0] out_lo,
   input logic [DW-1:0] out_hi
);
   logic [1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          live <= 2'd0;
      else if (live != 2'd2) live <= live + 2'd1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd0) |-> (!out_valid && out_lo == '0 && out_hi == '0)); // R12

   AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

   AST_MULH_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'b11)
      |-> (out_lo == '0)); // R10

   AST_MUL_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'b00 && $past(in_a, 2) == '0)
      |-> (out_lo == '0 && out_hi == '0)); // R7

   AST_MULA_PASS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 2'b01 && $past(in_a, 2) == '0)
      |-> (out_lo == $past(in_acc_lo, 2) && out_hi == $past(in_acc_hi, 2))); // R8

endmodule

bind pmac_simd_unit pmac_simd_unit_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_a      (in_a),
   .in_acc_lo (in_acc_lo),
   .in_acc_hi (in_acc_hi),
   .out_valid (out_valid),
   .out_lo    (out_lo),
   .out_hi    (out_hi)
);

// File: tb/pmac_simd_unit_bench.sv
`timescale 1ns/1ps
module pmac_simd_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [1:0]  in_part = 2'b00;
   logic        in_signed = 1'b0;
   logic [63:0] in_a = '0, in_b = '0, in_acc_lo = '0, in_acc_hi = '0;
   logic        out_valid;
   logic [63:0] out_lo, out_hi;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pmac_simd_unit u_pmac_simd_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_part(in_part), .in_signed(in_signed), .in_a(in_a), .in_b(in_b),
      .in_acc_lo(in_acc_lo), .in_acc_hi(in_acc_hi),
      .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi)
   );

   // behavioural lane model: returns {hi, lo}
   function automatic logic [127:0] model(input logic [1:0] op, input logic [1:0] part,
                                          input logic sgn, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] alo,
                                          input logic [63:0] ahi);
      int s, w;
      logic [63:0] lo, hi, smask, dmask, wmask, ar, br, accv, q;
      logic signed [63:0] av, bv, p, r;
      s = (part == 2'b00) ? 8 : (part == 2'b01) ? 16 : 32;
      w = (part == 2'b11) ? 24 : s;
      smask = (64'd1 << s) - 64'd1;
      dmask = (s == 32) ? '1 : ((64'd1 << (2*s)) - 64'd1);
      wmask = (64'd1 << w) - 64'd1;
      lo = '0;
      hi = '0;
      for (int i = 0; i < 64 / s; i++) begin
         ar = (a >> (s*i)) & wmask;
         br = (b >> (s*i)) & wmask;
         av = (sgn && ar[w-1]) ? $signed(ar - (64'd1 << w)) : $signed(ar);
         bv = (sgn && br[w-1]) ? $signed(br - (64'd1 << w)) : $signed(br);
         p  = av * bv;
         accv = ((((ahi >> (s*i)) & smask) << s) | ((alo >> (s*i)) & smask)) & dmask;
         if (op == 2'b11) begin
            r  = (p + (64'sd1 <<< (w-1))) >>> w;
            hi = hi | ((64'(r) & smask) << (s*i));
         end else begin
            if (op == 2'b01)      q = 64'(p) + accv;
            else if (op == 2'b10) q = 64'(p) - accv;
            else                  q = 64'(p);
            q  = q & dmask;
            lo = lo | ((q & smask) << (s*i));
            hi = hi | (((q >> s) & smask) << (s*i));
         end
      end
      return {hi, lo};
   endfunction

   function automatic string tag(input logic [1:0] op, input logic [1:0] part);
      string t;
      case (part)
         2'b00:   t = "R3";
         2'b01:   t = "R4";
         2'b10:   t = "R5";
         default: t = "R6";
      endcase
      case (op)
         2'b00:   t = {t, " R7"};
         2'b01:   t = {t, " R8"};
         2'b10:   t = {t, " R9"};
         default: t = {t, " R10"};
      endcase
      return {t, " R1 R11"};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // two-edge reference pipeline
   logic         m1_v, m2_v;
   logic [1:0]   m1_op, m2_op, m1_part, m2_part;
   logic [127:0] m1_res, m2_res;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_v <= 1'b0; m2_v <= 1'b0;
         m1_op <= '0; m2_op <= '0; m1_part <= '0; m2_part <= '0;
         m1_res <= '0; m2_res <= '0;
      end else begin
         m1_v    <= in_valid;
         m1_op   <= in_op;
         m1_part <= in_part;
         m1_res  <= model(in_op, in_part, in_signed, in_a, in_b, in_acc_lo, in_acc_hi);
         m2_v    <= m1_v;
         m2_op   <= m1_op;
         m2_part <= m1_part;
         m2_res  <= m1_res;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(out_valid == m2_v, "R2 valid", 128'(out_valid), 128'(m2_v));
         if (m2_v)
            chk({out_hi, out_lo} == m2_res, tag(m2_op, m2_part), {out_hi, out_lo}, m2_res);
      end
   end

   task automatic issue(input logic [1:0] op, input logic [1:0] part, input logic sgn,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] alo, input logic [63:0] ahi);
      in_valid  = 1'b1;
      in_op     = op;
      in_part   = part;
      in_signed = sgn;
      in_a      = a;
      in_b      = b;
      in_acc_lo = alo;
      in_acc_hi = ahi;
      @(negedge clk);
   endtask

   task automatic idle();
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      logic [63:0] pa [5];
      logic [63:0] pb [5];
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(out_valid == 1'b0, "R12 valid", 128'(out_valid), 128'(0));
      chk(out_lo == '0 && out_hi == '0, "R12 data", {out_hi, out_lo}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      pa[0] = '1;                    pb[0] = '1;
      pa[1] = 64'h8080_8080_8080_8080; pb[1] = 64'h8080_8080_8080_8080;
      pa[2] = 64'h8000_8000_8000_8000; pb[2] = 64'h7FFF_7FFF_7FFF_7FFF;
      pa[3] = '0;                    pb[3] = rnd64();
      pa[4] = 64'h00FF_FF80_0080_7F01; pb[4] = 64'hFF7F_8001_00FF_80FF;
      for (int pt = 0; pt < 4; pt++)
         for (int sg = 0; sg < 2; sg++)
            for (int op = 0; op < 4; op++)
               for (int k = 0; k < 5; k++)
                  issue(2'(op), 2'(pt), 1'(sg), pa[k], pb[k], rnd64(), rnd64());
      idle();
      idle();
      // R11: mixed modes every cycle with occasional gaps
      for (int n = 0; n < 1500; n++) begin
         if (($urandom() % 8) == 0) idle();
         else issue(2'($urandom()), 2'($urandom()), 1'($urandom()),
                    (($urandom() % 6) == 0) ? '0 : rnd64(), rnd64(), rnd64(), rnd64());
      end
      idle();
      idle();
      idle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule